// File: doc/BRIEF.md
# Serial-Expander Character Display Writer

This block takes command and data bytes meant for a character display controller running in 4-bit mode and delivers them through a three-wire serial link into an external 8-bit shift register with latched outputs. That expander in turn drives the display's four data lines, its register-select line and up to two enable lines, so that a display built from two controllers can be served over the same wires. Each byte accepted from the host is split into its upper and lower nibble. Every nibble goes out as two serial frames: the first with the chosen enable high and the second with it low and the data unchanged. The display therefore sees a falling enable edge with stable data and register-select.

The serial link works in mode 0, most significant bit first. The latch line of the expander acts as an active-low select. It falls before the first bit of a frame and rises after exactly eight clock pulses. The rising edge copies the shifted byte onto the expander outputs. The link has no return path, so the block cannot poll the display. After the last frame of a byte it holds its ready output low for a fixed settle time. The host selects a short time for data and ordinary commands and a long time for clear and home commands.

Top module: `lcd_spi_writer`

## Requirements
- R1: After reset, in_ready is 1, spi_sck is 0 and spi_latch_n is 1.
- R2: Every accepted byte produces exactly four serial frames. In each frame spi_latch_n is low for exactly eight rising edges of spi_sck. spi_mosi is stable while spi_sck is high.
- R3: Frame layout, most significant bit first: bits 7..4 carry the data nibble, bit 3 carries the register-select flag, bit 2 is the enable of controller 1, bit 1 is the enable of controller 0, and bit 0 is always 0.
- R4: The four frames go out in a fixed order: upper nibble with enable 1, upper nibble with enable 0, lower nibble with enable 1, lower nibble with enable 0.
- R5: in_ctrl_sel = 1 routes the enable pulse to bit 2 and in_ctrl_sel = 0 routes it to bit 1. The enable bit of the other controller is 0 in every frame.
- R6: spi_sck idles low, is low whenever spi_latch_n is high, and each high or low phase lasts SCK_HALF clock cycles.
- R7: With in_long_wait = 0, in_ready stays low for 68*SCK_HALF + WAIT_SHORT cycles after the accepting edge.
- R8: With in_long_wait = 1, in_ready stays low for 68*SCK_HALF + WAIT_LONG cycles after the accepting edge.
- R9: While no byte is in progress, spi_latch_n stays high and spi_sck stays low, whatever in_byte, in_rs and in_ctrl_sel do.
- R10: A byte is taken on a clock edge where in_valid and in_ready are both 1. Changes on the inputs while in_ready is low do not alter the frames being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host offers a byte |
| in_ready | output | 1 | Block can take a byte |
| in_byte | input | 8 | Command or data byte |
| in_rs | input | 1 | Register-select level for this byte |
| in_ctrl_sel | input | 1 | Chooses which controller gets the enable pulse |
| in_long_wait | input | 1 | Use the long settle time after this byte |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data, most significant bit first |
| spi_latch_n | output | 1 | Expander select and store line, rising edge stores |

## Verification
The bench builds the block with SCK_HALF = 2, WAIT_SHORT = 5 and WAIT_LONG = 40. A whole byte then takes about 140 to 180 cycles, so several hundred random bytes fit easily in the run. These values keep the short and long settle times well apart. A wrong count of serial phases or of wait cycles therefore shows up as a clear mismatch in the measured ready-low time. A half period of two cycles means each serial clock phase spans more than one system clock, so a divider error that only drops or adds a single cycle is also caught.

// File: rtl/lcd_spi_pkg.sv
package lcd_spi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LO,
        ST_HI,
        ST_GAP,
        ST_WAIT
    } wr_state_e;

    localparam int FRAME_BITS   = 8;
    localparam int FRAMES_PER_B = 4;
    localparam int POS_RS       = 3;
    localparam int POS_EN1      = 2;
    localparam int POS_EN0      = 1;

    typedef struct packed {
        wr_state_e  st;
        logic [7:0] shift;
        logic [2:0] bit_idx;
        logic [1:0] frame;
        logic [7:0] byte_q;
        logic       rs;
        logic       sel;
        logic       lng;
    } wr_core_s;

endpackage

// File: rtl/lcd_spi_tick.sv
module lcd_spi_tick #(
    parameter int SCK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(SCK_HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = cnt_q;
        if (clear || tick) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lcd_frame_build.sv
module lcd_frame_build
    import lcd_spi_pkg::*;
(
    input  logic [7:0] byte_in,
    input  logic       rs,
    input  logic       sel,
    input  logic [1:0] idx,
    output logic [7:0] frame
);
    logic [3:0] nib;
    logic       en;

    always_comb begin
        nib   = idx[1] ? byte_in[3:0] : byte_in[7:4];
        en    = ~idx[0];
        frame = '0;
        frame[7:4]     = nib;
        frame[POS_RS]  = rs;
        frame[POS_EN1] = en & sel;
        frame[POS_EN0] = en & ~sel;
    end
endmodule

// File: rtl/lcd_wait_timer.sv
module lcd_wait_timer #(
    parameter int WAIT_SHORT = 5,
    parameter int WAIT_LONG  = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic lng,
    output logic done
);
    localparam int MAXW = (WAIT_LONG > WAIT_SHORT) ? WAIT_LONG : WAIT_SHORT;
    localparam int WW   = $clog2(MAXW + 1);

    logic [WW-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = (cnt_q == WW'(1));
        cnt_d = cnt_q;
        if (load)             cnt_d = lng ? WW'(WAIT_LONG) : WW'(WAIT_SHORT);
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lcd_spi_writer.sv
module lcd_spi_writer
    import lcd_spi_pkg::*;
#(
    parameter int SCK_HALF   = 2,
    parameter int WAIT_SHORT = 5,
    parameter int WAIT_LONG  = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_byte,
    input  logic       in_rs,
    input  logic       in_ctrl_sel,
    input  logic       in_long_wait,
    output logic       spi_sck,
    output logic       spi_mosi,
    output logic       spi_latch_n
);
    localparam logic [2:0] LAST_BIT   = 3'(FRAME_BITS - 1);
    localparam logic [1:0] LAST_FRAME = 2'(FRAMES_PER_B - 1);

    wr_core_s q, d;

    logic       tick, tick_clear;
    logic       wait_load, wait_done;
    logic       take_new;
    logic [7:0] bld_byte, bld_frame;
    logic       bld_rs, bld_sel;
    logic [1:0] bld_idx;

    lcd_spi_tick #(.SCK_HALF(SCK_HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tick_clear),
        .tick  (tick)
    );

    lcd_wait_timer #(.WAIT_SHORT(WAIT_SHORT), .WAIT_LONG(WAIT_LONG)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wait_load),
        .lng   (q.lng),
        .done  (wait_done)
    );

    lcd_frame_build u_build (
        .byte_in (bld_byte),
        .rs      (bld_rs),
        .sel     (bld_sel),
        .idx     (bld_idx),
        .frame   (bld_frame)
    );

    always_comb begin
        take_new   = (q.st == ST_IDLE);
        bld_byte   = take_new ? in_byte     : q.byte_q;
        bld_rs     = take_new ? in_rs       : q.rs;
        bld_sel    = take_new ? in_ctrl_sel : q.sel;
        bld_idx    = take_new ? 2'd0        : q.frame + 2'd1;
        tick_clear = (q.st == ST_IDLE) || (q.st == ST_WAIT);
        wait_load  = (q.st == ST_GAP) && tick && (q.frame == LAST_FRAME);

        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    d.byte_q  = in_byte;
                    d.rs      = in_rs;
                    d.sel     = in_ctrl_sel;
                    d.lng     = in_long_wait;
                    d.shift   = bld_frame;
                    d.bit_idx = '0;
                    d.frame   = '0;
                    d.st      = ST_LO;
                end
            end
            ST_LO: begin
                if (tick) d.st = ST_HI;
            end
            ST_HI: begin
                if (tick) begin
                    if (q.bit_idx == LAST_BIT) begin
                        d.st = ST_GAP;
                    end else begin
                        d.bit_idx = q.bit_idx + 3'd1;
                        d.shift   = {q.shift[6:0], 1'b0};
                        d.st      = ST_LO;
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (q.frame == LAST_FRAME) begin
                        d.st = ST_WAIT;
                    end else begin
                        d.frame   = q.frame + 2'd1;
                        d.shift   = bld_frame;
                        d.bit_idx = '0;
                        d.st      = ST_LO;
                    end
                end
            end
            ST_WAIT: begin
                if (wait_done) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.shift   <= '0;
            q.bit_idx <= '0;
            q.frame   <= '0;
            q.byte_q  <= '0;
            q.rs      <= 1'b0;
            q.sel     <= 1'b0;
            q.lng     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign in_ready    = (q.st == ST_IDLE);
    assign spi_sck     = (q.st == ST_HI);
    assign spi_mosi    = q.shift[7];
    assign spi_latch_n = !((q.st == ST_LO) || (q.st == ST_HI));
endmodule

// File: rtl/lcd_spi_writer_chk.sv
module lcd_spi_writer_chk #(
    parameter int SCK_HALF   = 2,
    parameter int WAIT_SHORT = 5,
    parameter int WAIT_LONG  = 40
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic in_long_wait,
    input logic spi_sck,
    input logic spi_mosi,
    input logic spi_latch_n
);
    logic [31:0] busy_cnt;
    logic [3:0]  edge_cnt;
    logic        sck_prev;
    logic        lng_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            edge_cnt <= '0;
            sck_prev <= 1'b0;
            lng_cap  <= 1'b0;
        end else begin
            sck_prev <= spi_sck;
            if (in_ready) busy_cnt <= '0;
            else          busy_cnt <= busy_cnt + 32'd1;
            if (in_valid && in_ready) lng_cap <= in_long_wait;
            if (spi_latch_n)                edge_cnt <= '0;
            else if (spi_sck && !sck_prev)  edge_cnt <= edge_cnt + 4'd1;
        end
    end

    assert_sck_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_latch_n |-> !spi_sck);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (spi_latch_n && !spi_sck));

    assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    assert_eight_edges_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_latch_n) |-> (edge_cnt == 4'd8));

    assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!in_ready && !spi_latch_n));

    // covers R7 (short) and R8 (long)
    assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |->
            (busy_cnt == 32'(68 * SCK_HALF + (lng_cap ? WAIT_LONG : WAIT_SHORT))));
endmodule

bind lcd_spi_writer lcd_spi_writer_chk #(
    .SCK_HALF   (SCK_HALF),
    .WAIT_SHORT (WAIT_SHORT),
    .WAIT_LONG  (WAIT_LONG)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_long_wait (in_long_wait),
    .spi_sck      (spi_sck),
    .spi_mosi     (spi_mosi),
    .spi_latch_n  (spi_latch_n)
);

// File: tb/lcd_spi_writer_test.sv
module lcd_spi_writer_test;
    localparam int HALF = 2;
    localparam int WS   = 5;
    localparam int WL   = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_byte = 8'h00;
    logic       in_rs = 1'b0;
    logic       in_ctrl_sel = 1'b0;
    logic       in_long_wait = 1'b0;
    logic       spi_sck, spi_mosi, spi_latch_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    lcd_spi_writer #(.SCK_HALF(HALF), .WAIT_SHORT(WS), .WAIT_LONG(WL)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .in_rs(in_rs), .in_ctrl_sel(in_ctrl_sel),
        .in_long_wait(in_long_wait), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_latch_n(spi_latch_n)
    );

    // expander model
    logic [7:0] shreg = 8'h00;
    int         bitcnt = 0;
    logic [7:0] frames [0:63];
    int         fbits  [0:63];
    int         nfr = 0;

    always @(posedge spi_sck) begin
        shreg  = {shreg[6:0], spi_mosi};
        bitcnt = bitcnt + 1;
    end
    always @(negedge spi_latch_n) bitcnt = 0;
    always @(posedge spi_latch_n) begin
        if (nfr < 64) begin
            frames[nfr] = shreg;
            fbits[nfr]  = bitcnt;
        end
        nfr = nfr + 1;
    end

    // SCK phase width monitor
    int hi_run = 0, lo_run = 0, bad_hi = 0, bad_lo = 0;
    always @(negedge clk) begin
        if (spi_sck) begin
            hi_run = hi_run + 1;
            if (lo_run != 0 && lo_run != HALF && !spi_latch_n) bad_lo = bad_lo + 1;
            lo_run = 0;
        end else begin
            if (hi_run != 0 && hi_run != HALF) bad_hi = bad_hi + 1;
            hi_run = 0;
            if (!spi_latch_n) lo_run = lo_run + 1;
            else              lo_run = 0;
        end
    end

    function automatic logic [7:0] exp_frame(logic [7:0] b, logic rs, logic sel, int k);
        logic [3:0] nib;
        logic       en;
        nib = (k < 2) ? b[7:4] : b[3:0];
        en  = (k % 2) == 0;
        return {nib, rs, en & sel, en & ~sel, 1'b0};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(logic [7:0] b, logic rs, logic sel, logic lng, bit scramble);
        int n;
        int base;
        int expw;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        base = 0;
        nfr  = 0;
        in_valid = 1'b1; in_byte = b; in_rs = rs; in_ctrl_sel = sel; in_long_wait = lng;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (scramble) begin   // R10: inputs moved while busy
            in_byte = ~b; in_rs = ~rs; in_ctrl_sel = ~sel; in_long_wait = ~lng;
        end
        n = 0;
        while (!in_ready) begin
            n++;
            @(negedge clk);
        end
        expw = 68 * HALF + (lng ? WL : WS);
        check(n == expw, lng ? "R8 busy length" : "R7 busy length", n, expw);
        check(nfr == 4, "R2 frame count", nfr, 4);
        for (int k = 0; k < 4; k++) begin
            check(fbits[base+k] == 8, "R2 bits per frame", fbits[base+k], 8);
            check(frames[base+k] == exp_frame(b, rs, sel, k),
                  scramble ? "R10 frame content" : "R3/R4/R5 frame content",
                  frames[base+k], exp_frame(b, rs, sel, k));
        end
    endtask

    initial begin
        logic [7:0] rb;
        int startn;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1,    "R1 ready", in_ready, 1);
        check(spi_sck == 1'b0,     "R1 sck", spi_sck, 0);
        check(spi_latch_n == 1'b1, "R1 latch", spi_latch_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        nfr = 0;
        // R9: idle inputs wiggle, no latch activity
        for (int i = 0; i < 40; i++) begin
            in_byte = 8'($urandom); in_rs = 1'($urandom); in_ctrl_sel = 1'($urandom);
            @(negedge clk);
        end
        check(nfr == 0, "R9 idle no frames", nfr, 0);
        check(spi_latch_n == 1'b1 && spi_sck == 1'b0, "R9 idle lines", {spi_latch_n, spi_sck}, 2);
        // directed corners: R3 R4 R5
        send(8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'hFF, 1'b1, 1'b1, 1'b0, 1'b0);
        send(8'hA5, 1'b1, 1'b0, 1'b1, 1'b0);   // R8
        send(8'h3C, 1'b0, 1'b1, 1'b1, 1'b1);   // R10
        // random mix
        for (int i = 0; i < 300; i++) begin
            rb = 8'($urandom);
            send(rb, 1'($urandom), 1'($urandom), ($urandom % 4) == 0, 1'($urandom));
        end
        // R6 phase widths
        check(bad_hi == 0, "R6 sck high width", bad_hi, 0);
        check(bad_lo == 0, "R6 sck low width", bad_lo, 0);
        // R9 after traffic
        startn = nfr;
        repeat (30) @(negedge clk);
        check(nfr == startn, "R9 no frames after done", nfr, startn);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule